// File: doc/BRIEF.md
# Page-Mode Read Controller

This block sits on the host side of a parallel NOR-style memory that can return data faster when consecutive reads fall in the same 8-word page. It accepts single-word read requests over a valid/ready handshake and drives the memory's active-low select, active-low output-enable and address lines. It waits a fixed number of clock cycles, registers the memory data and returns it with a one-cycle valid strobe.

The controller keeps a registered page tag and a valid flag for the open page. A page is identified by the address bits above bit 2, and the low three bits pick the word inside it. A request whose page matches the open page while the device stays selected is served with the short in-page latency. Every other request pays the full access latency. After a programmable number of idle cycles without a request, the controller releases the select line and forgets the page. The next read is then a full-latency access.

Top module: `pgrd_ctrl`

## Requirements
- R1: During and right after synchronous reset, `mem_ce_n` and `mem_oe_n` are 1, `rsp_valid` is 0 and `req_ready` is 1. Reset also forgets the open page.
- R2: A read accepted while no page is open returns `rsp_valid` exactly FULL_LAT cycles after the accepting clock edge. `rsp_data` then equals the memory word at the requested address.
- R3: A read accepted while the device is selected, a page is open and `req_addr[ADDR_W-1:3]` equals the open page returns after exactly PAGE_LAT cycles.
- R4: A read to a different page while the device is selected returns after exactly FULL_LAT cycles and becomes the new open page.
- R5: `mem_oe_n` is 0 only while `mem_ce_n` is 0, and only during the last OE_LAT cycles of an access. The address is therefore stable for at least the access latency minus OE_LAT cycles before output enable falls.
- R6: Each accepted read produces exactly one `rsp_valid` cycle. That cycle directly follows a cycle in which output enable was asserted.
- R7: `req_ready` is 1 when the controller is idle and in the final latency cycle of an access, and 0 otherwise. This allows back-to-back reads with no dead cycle.
- R8: After IDLE_CYCLES consecutive idle cycles with the device selected and no request, `mem_ce_n` returns to 1 and the page is forgotten. The next read takes FULL_LAT cycles.
- R9: `mem_addr` does not change while an access is in progress (`req_ready` low).
- R10: The first read after reset takes FULL_LAT cycles even if its page equals the page open before reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_addr | input | ADDR_W | Word address of the request |
| rsp_valid | output | 1 | One-cycle strobe: `rsp_data` holds a read result |
| rsp_data | output | DATA_W | Registered read data |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | ADDR_W | Memory word address |
| mem_dq | input | DATA_W | Memory read data |

## Verification
The bench builds the controller with FULL_LAT=5, PAGE_LAT=2, OE_LAT=2, IDLE_CYCLES=6 and a 12-bit address.

- The short idle limit lets a few quiet cycles release the select line and reach the timeout path (R8) many times in a short run.
- The gap between the two latencies makes any wrong hit/miss choice visible as a three-cycle shift.
- Making the in-page latency equal to the output-enable window checks the tightest case, where output enable is low for the whole page access.
- The behavioural memory returns poison data for any sample taken before the address or output-enable time is met. It keeps its own view of the open page, so an early sample shows up as a data mismatch.

// File: rtl/pgrd_pkg.sv
package pgrd_pkg;

    // Low address bits that select a word inside a page (8 words per page)
    localparam int unsigned WORD_SEL_W = 3;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ACCESS = 1'b1
    } pgrd_state_e;

    // Per-cycle control events of the controller
    typedef struct packed {
        logic accept;   // request taken this cycle
        logic finish;   // last latency cycle of an access
        logic hit;      // request address lies in the open page
        logic expire;   // idle limit reached, release the device
    } pgrd_evt_t;

    function automatic int unsigned pick_latency(input logic hit,
                                                 input int unsigned full_c,
                                                 input int unsigned page_c);
        return hit ? page_c : full_c;
    endfunction

endpackage

// File: rtl/pgrd_page_tag.sv
module pgrd_page_tag #(
    parameter int unsigned TAG_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             load,
    input  logic [TAG_W-1:0] tag_in,
    output logic             hit
);
    logic             tag_vld;
    logic [TAG_W-1:0] tag_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tag_vld <= 1'b0;
            tag_q   <= '0;
        end else if (load) begin
            tag_vld <= 1'b1;
            tag_q   <= tag_in;
        end
    end

    assign hit = tag_vld && (tag_q == tag_in);

endmodule

// File: rtl/pgrd_lat_cnt.sv
module pgrd_lat_cnt #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == CNT_W'(1));

endmodule

// File: rtl/pgrd_idle_timer.sv
module pgrd_idle_timer #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic expire
);
    localparam int unsigned IW = $clog2(LIMIT + 1);

    logic [IW-1:0] count;

    assign expire = run && (count == IW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clr || expire) begin
            count <= '0;
        end else if (run) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/pgrd_ctrl.sv
module pgrd_ctrl #(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned FULL_LAT    = 5,
    parameter int unsigned PAGE_LAT    = 2,
    parameter int unsigned OE_LAT      = 2,
    parameter int unsigned IDLE_CYCLES = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_dq
);
    import pgrd_pkg::*;

    localparam int unsigned TAG_W = ADDR_W - WORD_SEL_W;
    localparam int unsigned CNT_W = $clog2(FULL_LAT + 1);

    generate
        if (PAGE_LAT < 1 || OE_LAT < 1 || PAGE_LAT > FULL_LAT ||
            OE_LAT > PAGE_LAT || IDLE_CYCLES < 1 || ADDR_W <= WORD_SEL_W) begin : g_bad_cfg
            $error("pgrd_ctrl: inconsistent latency or width parameters");
        end
    endgenerate

    pgrd_state_e      st_q;
    pgrd_evt_t        ev;
    logic [CNT_W-1:0] lat_cnt;
    logic             lat_last;
    logic             page_hit;
    logic             idle_run;

    // Page tag and valid flag; released select discards the page
    pgrd_page_tag #(.TAG_W(TAG_W)) u_tag (
        .clk    (clk),
        .rst    (rst),
        .clr    (ev.expire),
        .load   (ev.accept),
        .tag_in (req_addr[ADDR_W-1:WORD_SEL_W]),
        .hit    (page_hit)
    );

    pgrd_lat_cnt #(.CNT_W(CNT_W)) u_lat (
        .clk      (clk),
        .rst      (rst),
        .load     (ev.accept),
        .load_val (CNT_W'(pick_latency(ev.hit, FULL_LAT, PAGE_LAT))),
        .cnt      (lat_cnt),
        .last     (lat_last)
    );

    pgrd_idle_timer #(.LIMIT(IDLE_CYCLES)) u_idle (
        .clk    (clk),
        .rst    (rst),
        .clr    (ev.accept || ev.finish),
        .run    (idle_run),
        .expire (ev.expire)
    );

    always_comb begin
        ev.finish = (st_q == ST_ACCESS) && lat_last;
        req_ready = (st_q == ST_IDLE) || ev.finish;
        ev.accept = req_valid && req_ready;
        ev.hit    = page_hit;
    end

    assign idle_run = (st_q == ST_IDLE) && !mem_ce_n && !ev.accept;

    // Output enable covers the trailing OE_LAT cycles of every access
    assign mem_oe_n = !((st_q == ST_ACCESS) && (lat_cnt <= CNT_W'(OE_LAT)));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            mem_ce_n <= 1'b1;
            mem_addr <= '0;
        end else begin
            if (ev.accept) begin
                st_q     <= ST_ACCESS;
                mem_ce_n <= 1'b0;
                mem_addr <= req_addr;
            end else begin
                if (ev.finish) begin
                    st_q <= ST_IDLE;
                end
                if (ev.expire) begin
                    mem_ce_n <= 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= ev.finish;
            if (ev.finish) begin
                rsp_data <= mem_dq;
            end
        end
    end

endmodule

// File: rtl/pgrd_chk.sv
module pgrd_chk #(
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic [ADDR_W-1:0] mem_addr
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (mem_ce_n && mem_oe_n && !rsp_valid && req_ready));

    // R5
    oe_needs_ce_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_ce_n);

    // R6
    rsp_after_oe_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(!mem_oe_n));

    // R7
    rsp_ready_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_ready));

    // R8
    ce_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_ce_n) |-> $past(req_ready && !req_valid));

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> $stable(mem_addr));

endmodule

bind pgrd_ctrl pgrd_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_addr  (mem_addr)
);

// File: tb/pgrd_ctrl_tb_top.sv
module pgrd_ctrl_tb_top;
    localparam int AW    = 12;
    localparam int DW    = 16;
    localparam int FULL  = 5;
    localparam int PAGE  = 2;
    localparam int OEL   = 2;
    localparam int IDLEC = 6;
    localparam logic [DW-1:0] POISON = 16'hDEAD;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic          mem_ce_n;
    logic          mem_oe_n;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq = POISON;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #4 clk = ~clk;   // 8-unit period: 125 MHz

    pgrd_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .FULL_LAT(FULL), .PAGE_LAT(PAGE),
        .OE_LAT(OEL), .IDLE_CYCLES(IDLEC)
    ) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
        .mem_dq(mem_dq)
    );

    function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
        return {4'h1, a ^ 12'h3C3};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- reference model (updated at every rising edge) -------
    typedef struct {
        int            at;
        int            lat;
        int            reason;   // 0 after reset, 1 in-page, 2 page change, 3 after timeout
    } acc_t;

    acc_t          acc_q[$];
    bit            m_busy, m_ce, m_pv, m_valid, m_fresh;
    int            m_remain, m_tag, m_idle;
    logic [AW-1:0] m_addr;
    logic [DW-1:0] m_data;

    always @(posedge clk) begin
        bit fin, can, busy_pre, hit;
        acc_t e;
        cyc++;
        if (rst) begin
            m_busy = 0; m_ce = 0; m_pv = 0; m_valid = 0; m_fresh = 1;
            m_remain = 0; m_idle = 0;
            acc_q.delete();
        end else begin
            busy_pre = m_busy;
            fin = m_busy && (m_remain == 1);
            can = !m_busy || fin;
            m_valid = 0;
            if (m_busy) begin
                m_remain--;
                if (m_remain == 0) begin
                    m_valid = 1;
                    m_data  = word_of(m_addr);
                    m_busy  = 0;
                    m_idle  = 0;
                end
            end
            if (can && req_valid) begin
                hit = m_ce && m_pv && (m_tag == int'(req_addr[AW-1:3]));
                e.at  = cyc;
                e.lat = hit ? PAGE : FULL;
                if (hit)          e.reason = 1;
                else if (m_fresh) e.reason = 0;
                else if (!m_ce)   e.reason = 3;
                else              e.reason = 2;
                acc_q.push_back(e);
                m_remain = e.lat; m_busy = 1; m_ce = 1; m_pv = 1;
                m_tag = int'(req_addr[AW-1:3]); m_addr = req_addr;
                m_idle = 0; m_fresh = 0;
            end else if (!busy_pre && m_ce) begin
                m_idle++;
                if (m_idle == IDLEC) begin
                    m_ce = 0; m_pv = 0; m_idle = 0;
                end
            end
        end
    end

    // ---------------- behavioural memory state ----------------------------
    int            mc_addr_cyc = 0, mc_oe_cyc = 0, mc_tag = 0;
    bit            mc_open = 0;
    logic [AW-1:0] mc_last = '0;

    // ---------------- per-cycle comparison and memory update ---------------
    always @(negedge clk) begin
        acc_t e;
        int need;
        chk(req_ready === (!m_busy || m_remain == 1), "R7", "req_ready", req_ready, !m_busy || m_remain == 1);
        chk(mem_ce_n === !m_ce, "R8", "mem_ce_n", mem_ce_n, !m_ce);
        chk(rsp_valid === m_valid, "R6", "rsp_valid", rsp_valid, m_valid);
        if (m_valid)
            chk(rsp_data === m_data, "R2", "rsp_data (early sample gives dead)", rsp_data, m_data);
        chk(mem_oe_n || !mem_ce_n, "R5", "oe while deselected", mem_oe_n, 1);
        if (m_busy)
            chk(mem_addr === m_addr, "R9", "mem_addr", mem_addr, m_addr);
        if (rsp_valid && acc_q.size() > 0) begin
            e = acc_q.pop_front();
            case (e.reason)
                0: chk(cyc - e.at == e.lat, "R10", "latency after reset", cyc - e.at, e.lat);
                1: chk(cyc - e.at == e.lat, "R3", "in-page latency", cyc - e.at, e.lat);
                2: chk(cyc - e.at == e.lat, "R4", "page-change latency", cyc - e.at, e.lat);
                default: chk(cyc - e.at == e.lat, "R8", "latency after timeout", cyc - e.at, e.lat);
            endcase
        end

        // memory: data only once address and output-enable times are met
        if (mem_ce_n) begin
            mc_addr_cyc = 0; mc_oe_cyc = 0; mc_open = 0;
        end else begin
            mc_addr_cyc = (mem_addr != mc_last) ? 1 : mc_addr_cyc + 1;
            mc_oe_cyc   = mem_oe_n ? 0 : mc_oe_cyc + 1;
        end
        need = (mc_open && mc_tag == int'(mem_addr[AW-1:3])) ? PAGE : FULL;
        if (!mem_ce_n && mc_addr_cyc >= FULL) begin
            mc_open = 1;
            mc_tag  = int'(mem_addr[AW-1:3]);
        end
        mc_last = mem_addr;
        mem_dq = (!mem_ce_n && !mem_oe_n && mc_addr_cyc >= need && mc_oe_cyc >= OEL)
                 ? word_of(mem_addr) : POISON;
    end

    // ---------------- stimulus ---------------------------------------------
    task automatic issue(input logic [AW-1:0] a);
        bit r;
        req_valid = 1'b1;
        req_addr  = a;
        do begin
            r = req_ready;
            @(posedge clk);
            @(negedge clk);
        end while (!r);
    endtask

    task automatic pause(input int n);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        req_valid = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle state after reset
        chk(mem_ce_n === 1'b1, "R1", "mem_ce_n", mem_ce_n, 1);
        chk(mem_oe_n === 1'b1, "R1", "mem_oe_n", mem_oe_n, 1);
        chk(rsp_valid === 1'b0, "R1", "rsp_valid", rsp_valid, 0);
        chk(req_ready === 1'b1, "R1", "req_ready", req_ready, 1);
    endtask

    bit done = 0;

    initial begin
        logic [15:0] lfsr;
        repeat (2) @(negedge clk);
        do_reset();

        // R2 then R3: sequential words inside one page, back to back
        for (int i = 0; i < 8; i++) issue(12'h010 + 12'(i));
        // R4: cross into next page, random jump, return, in-page hit
        issue(12'h018); issue(12'h0A3); issue(12'h0A5); issue(12'h3F0);
        pause(3);                      // shorter than the idle limit
        issue(12'h3F2);                // R3 still open
        pause(IDLEC + FULL + 3);       // R8 timeout releases select
        issue(12'h3F4);
        pause(FULL + 2);
        do_reset();                    // R10 page forgotten by reset
        issue(12'h3F5); issue(12'h3F6);
        issue(12'h3F6);                // same word again: in-page

        lfsr = 16'hACE1;
        for (int i = 0; i < 60; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            issue({2'b00, lfsr[9:8], 5'b0, lfsr[2:0]} ^ 12'h240);
            if (lfsr[6:4] == 3'd7)      pause(IDLEC + FULL + 1);
            else if (lfsr[6:4] == 3'd3) pause(2);
        end
        pause(FULL + IDLEC + 4);
        chk(acc_q.size() == 0, "R6", "responses missing", acc_q.size(), 0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule